// File: doc/BRIEF.md
# Digitizer link initialization sequencer

This block decides when the capture interface of a multi-ADC digitizer is brought up again, and then runs that bring-up. Three events request a start: a rising edge on the I/O-enable input, any change of the sample-clock select code, and a one-cycle force strobe. After a start the block drives a fixed chain of handshakes with external circuits. First the receive PLL is reset and the block waits for lock. Then the deserializer is reset, the capture delays are recalibrated and the ADC devices are aligned with each other. The block then clears its sticky health flags and raises `init_done`.

After bring-up the block watches the interface health. Each ADC has a flag that latches when that ADC reports a sampling window that is too narrow. A PLL flag latches on any loss of lock. The selected sample clock is forced low while the PLL is out of lock. A phase whose acknowledge never arrives is ended by a timeout, which leaves `init_done` low and raises a timeout flag. Only a start that runs through to its clear phase clears the health flags. Only a start of any kind clears the timeout flag.

Top module: `adc_link_init_seq`

## Requirements
- R1: A rising edge of `io_enable`, a `clk_sel` value that differs from the value sampled one cycle earlier, or `force_init` high starts a sequence. After reset the comparison value for `clk_sel` is 0.
- R2: `init_done` is low in the cycle after any start request is sampled. It stays low until the clear phase of that sequence has completed.
- R3: `adc_reg_reset` pulses high for exactly one cycle, in the cycle after an `io_enable` rising edge. This also holds when another trigger arrives in the same cycle. A start caused only by `force_init` or only by a `clk_sel` change produces no pulse.
- R4: The phases run in a fixed order, and at most one handshake output is high at a time:
  - `pll_rst` is high for one cycle, and the block waits for `pll_locked`.
  - `deser_rst` is held high until `deser_done`.
  - `cal_req` is held high until `cal_done`.
  - `align_req` is held high until `align_done`.
  - One clear cycle follows, and then `init_done` rises.
- R5: While `init_done` is high, `win_short[i]` high sets `adc_err[i]` at the next edge. The bit then stays set until the clear phase of the next sequence.
- R6: While `init_done` is high, `pll_locked` low sets `pll_unlocked` at the next edge. The flag stays set after lock returns, until the clear phase of the next sequence.
- R7: `sample_clk` equals `src_clk[clk_sel]` for codes 0, 1 and 2, and is 0 for code 3. It is forced to 0 whenever `pll_locked` is low.
- R8: If a waiting phase receives no acknowledge within TIMEOUT cycles, the block sets `phase_timeout`, drops all handshake outputs and holds `init_done` low. The next start clears `phase_timeout`.
- R9: A start request arriving during a sequence sends the block back to the PLL reset phase in the next cycle. The remaining phases are then run again in full.
- R10: After reset, `init_done`, all handshake outputs, `adc_reg_reset` and all flags are 0 until a start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_enable | input | 1 | I/O enable level; its rising edge starts a sequence with ADC register reset |
| clk_sel | input | SEL_W | Sample-clock source select code |
| force_init | input | 1 | One-cycle forced start strobe |
| src_clk | input | NUM_SRC | Candidate sample-clock sources |
| pll_locked | input | 1 | Receive PLL lock indication |
| deser_done | input | 1 | Deserializer reset acknowledge |
| cal_done | input | 1 | Delay recalibration acknowledge |
| align_done | input | 1 | Inter-ADC alignment acknowledge |
| win_short | input | NUM_ADC | Per-ADC sampling window below minimum |
| pll_rst | output | 1 | PLL reset request |
| deser_rst | output | 1 | Deserializer reset request |
| cal_req | output | 1 | Delay recalibration request |
| align_req | output | 1 | ADC alignment request |
| adc_reg_reset | output | 1 | Reset pulse for all ADC registers |
| init_done | output | 1 | Bring-up complete |
| adc_err | output | NUM_ADC | Sticky per-ADC window error flags |
| pll_unlocked | output | 1 | Sticky loss-of-lock flag |
| phase_timeout | output | 1 | Sticky phase timeout flag |
| sample_clk | output | 1 | Selected, lock-gated sample clock |

## Verification
Two start triggers can land in the same cycle. The bench raises `io_enable` in the same cycle as a `force_init` strobe, and also changes `clk_sel` together with a strobe. It then judges that exactly one sequence runs, with one register-reset pulse in the first case and none in the second. A start request can also coincide with a phase that is still waiting for its acknowledge. The bench strobes `force_init` while `cal_req` is high and checks that `pll_rst` appears in the next cycle. It then checks that the rerun completes in the full phase order with no leftover acknowledge from the aborted pass.

// File: rtl/adc_link_init_seq.sv
module adc_link_init_seq #(
  parameter int NUM_ADC = 2,
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_enable,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               force_init,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               pll_locked,
  input  logic               deser_done,
  input  logic               cal_done,
  input  logic               align_done,
  input  logic [NUM_ADC-1:0] win_short,
  output logic               pll_rst,
  output logic               deser_rst,
  output logic               cal_req,
  output logic               align_req,
  output logic               adc_reg_reset,
  output logic               init_done,
  output logic [NUM_ADC-1:0] adc_err,
  output logic               pll_unlocked,
  output logic               phase_timeout,
  output logic               sample_clk
);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PLL_RST, S_PLL_WAIT, S_DESER, S_CAL, S_ALIGN, S_CLR, S_DONE, S_FAIL
  } state_t;

  state_t           state, nxt;
  logic [TW-1:0]    tmr;
  logic             io_q;
  logic [SEL_W-1:0] sel_q;
  logic             io_rise, start, waiting, got;
  logic             src_pick;

  assign io_rise = io_enable & ~io_q;
  assign start   = io_rise | (clk_sel != sel_q) | force_init;

  assign pll_rst   = (state == S_PLL_RST);
  assign deser_rst = (state == S_DESER);
  assign cal_req   = (state == S_CAL);
  assign align_req = (state == S_ALIGN);
  assign init_done = (state == S_DONE);

  assign waiting = (state == S_PLL_WAIT) || deser_rst || cal_req || align_req;

  always_comb begin
    got = 1'b0;
    nxt = state;
    case (state)
      S_PLL_RST:  nxt = S_PLL_WAIT;
      S_PLL_WAIT: begin got = pll_locked; if (got) nxt = S_DESER; end
      S_DESER:    begin got = deser_done; if (got) nxt = S_CAL;   end
      S_CAL:      begin got = cal_done;   if (got) nxt = S_ALIGN; end
      S_ALIGN:    begin got = align_done; if (got) nxt = S_CLR;   end
      S_CLR:      nxt = S_DONE;
      default:    nxt = state;
    endcase
    if (waiting && !got && tmr == TW'(TIMEOUT - 1)) nxt = S_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      tmr           <= '0;
      io_q          <= 1'b0;
      sel_q         <= '0;
      adc_reg_reset <= 1'b0;
      phase_timeout <= 1'b0;
    end else begin
      io_q          <= io_enable;
      sel_q         <= clk_sel;
      adc_reg_reset <= io_rise;
      if (start) begin
        state         <= S_PLL_RST;
        tmr           <= '0;
        phase_timeout <= 1'b0;
      end else if (nxt != state) begin
        state <= nxt;
        tmr   <= '0;
        if (nxt == S_FAIL) phase_timeout <= 1'b1;
      end else if (waiting) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_err      <= '0;
      pll_unlocked <= 1'b0;
    end else if (state == S_CLR) begin
      adc_err      <= '0;
      pll_unlocked <= 1'b0;
    end else if (init_done) begin
      adc_err <= adc_err | win_short;
      if (!pll_locked) pll_unlocked <= 1'b1;
    end
  end

  assign src_pick   = (int'(clk_sel) < NUM_SRC) ? src_clk[clk_sel] : 1'b0;
  assign sample_clk = src_pick & pll_locked;

  // R2: init_done falls right after a start
  a_r2_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !init_done);
  // R9: any start lands in the PLL reset phase
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pll_rst);
  // R4: never two handshakes at once
  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pll_rst, deser_rst, cal_req, align_req}));
  // R3: register reset only follows an enable edge
  a_r3_regrst_src: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reg_reset |-> ($past(io_enable) && !$past(io_q)));
  // R5: error bits stay set outside the clear phase
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_CLR) |=> ((adc_err & $past(adc_err)) == $past(adc_err)));
  // R6: loss of lock after bring-up latches the flag
  a_r6_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !pll_locked) |=> pll_unlocked);
  // R7: clock is quiet while unlocked
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |-> !sample_clk);
  // R8: a timed-out sequence never reports done
  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    phase_timeout |-> (!init_done && !deser_rst && !cal_req && !align_req));
endmodule

// File: tb/adc_link_init_seq_test.sv
module adc_link_init_seq_test;
  logic clk = 0, rst_n = 0;
  logic io_enable = 0, force_init = 0;
  logic [1:0] clk_sel = 0;
  logic [2:0] src_clk = 0;
  logic pll_locked, deser_done, cal_done, align_done;
  logic [1:0] win_short = 0;
  logic pll_rst, deser_rst, cal_req, align_req, adc_reg_reset, init_done;
  logic [1:0] adc_err;
  logic pll_unlocked, phase_timeout, sample_clk;

  int vectors = 0, miscompares = 0;
  logic resp_en = 1, kill_lock = 0;
  logic [2:0] lcnt;
  int rr_cnt = 0;
  logic [15:0] order;
  logic p_pll, p_des, p_cal, p_aln;

  always #4 clk = ~clk;

  adc_link_init_seq uut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      pll_locked <= 0; lcnt <= 0; deser_done <= 0; cal_done <= 0; align_done <= 0;
    end else begin
      if (pll_rst || kill_lock) begin pll_locked <= 0; lcnt <= 0; end
      else if (!pll_locked) begin lcnt <= lcnt + 1; if (lcnt == 3) pll_locked <= 1; end
      deser_done <= deser_rst & resp_en;
      cal_done   <= cal_req & resp_en;
      align_done <= align_req & resp_en;
    end
  end

  always @(posedge clk) begin
    p_pll <= pll_rst; p_des <= deser_rst; p_cal <= cal_req; p_aln <= align_req;
    if (adc_reg_reset) rr_cnt <= rr_cnt + 1;
    if (pll_rst && !p_pll) order <= 16'h0001;
    else if (deser_rst && !p_des) order <= {order[11:0], 4'h2};
    else if (cal_req && !p_cal) order <= {order[11:0], 4'h3};
    else if (align_req && !p_aln) order <= {order[11:0], 4'h4};
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output logic ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (init_done) begin ok = 1; break; end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  typedef struct packed { logic [1:0] kind; logic [1:0] sel; logic rr; } vec_t;
  localparam vec_t VT [6] = '{
    '{2'd0, 2'd0, 1'b1},
    '{2'd1, 2'd1, 1'b0},
    '{2'd2, 2'd1, 1'b0},
    '{2'd1, 2'd2, 1'b0},
    '{2'd3, 2'd2, 1'b1},
    '{2'd2, 2'd2, 1'b0}
  };

  initial begin
    repeat (300000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic ok;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {init_done, pll_rst, deser_rst, cal_req, align_req, adc_reg_reset}, 0);
    check("R10", {adc_err, pll_unlocked, phase_timeout}, 0);

    foreach (VT[k]) begin
      base = rr_cnt;
      if (VT[k].kind == 0 || VT[k].kind == 3) begin
        io_enable = 0; @(negedge clk); @(negedge clk);
      end
      io_enable = 1;
      clk_sel = VT[k].sel;
      force_init = (VT[k].kind >= 2);
      @(negedge clk);
      force_init = 0;
      check("R2", init_done, 0);
      check("R1", pll_rst, 1);
      wait_done(ok);
      check("R1", ok, 1);
      check("R4", order, 16'h1234);
      check("R3", rr_cnt - base, VT[k].rr);
      check("R5", adc_err, 0);
    end

    // R7 clock mux and gating
    clk_sel = 2; src_clk = 3'b100; @(negedge clk);
    check("R7", sample_clk, 1);
    src_clk = 3'b011; @(negedge clk);
    check("R7", sample_clk, 0);

    // R5 sticky ADC error
    win_short = 2'b01; @(negedge clk); win_short = 0; @(negedge clk);
    check("R5", adc_err, 2'b01);
    repeat (3) @(negedge clk);
    check("R5", adc_err, 2'b01);

    // R6 unlock latch and R7 gating
    src_clk = 3'b100;
    kill_lock = 1; @(negedge clk); kill_lock = 0;
    check("R7", sample_clk, 0);
    @(negedge clk);
    check("R6", pll_unlocked, 1);
    repeat (8) @(negedge clk);
    check("R6", {pll_locked, pll_unlocked}, 2'b11);
    force_init = 1; @(negedge clk); force_init = 0;
    wait_done(ok);
    check("R6", pll_unlocked, 0);
    check("R5", adc_err, 0);

    // R9 restart mid-sequence
    force_init = 1; @(negedge clk); force_init = 0;
    for (int i = 0; i < 50 && !cal_req; i++) @(negedge clk);
    check("R9", cal_req, 1);
    force_init = 1; @(negedge clk); force_init = 0;
    check("R9", {pll_rst, cal_req}, 2'b10);
    wait_done(ok);
    check("R9", {ok, order}, {1'b1, 16'h1234});

    // R3 sel change with force in the same cycle: one start, no pulse
    base = rr_cnt;
    clk_sel = 0; force_init = 1; @(negedge clk); force_init = 0;
    wait_done(ok);
    check("R3", rr_cnt - base, 0);

    // R8 timeout
    resp_en = 0;
    force_init = 1; @(negedge clk); force_init = 0;
    repeat (120) @(negedge clk);
    check("R8", {phase_timeout, init_done, deser_rst}, 3'b100);
    resp_en = 1;
    force_init = 1; @(negedge clk); force_init = 0;
    check("R8", phase_timeout, 0);
    wait_done(ok);
    check("R8", ok, 1);

    finish_run();
  end
endmodule